// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows every instruction through a five-stage pipeline (fetch, decode, execute, memory, writeback) and carries a small status record with it. The record holds the instruction's PC, whether the instruction sits in the delay slot of a delayed branch, the PC of that branch, and an exception field of one valid bit plus a cause code. Any of the first four stages may raise a fault for the instruction it holds, in any order: a younger instruction may fault before an older one. A fault is not acted on when it is raised. It is written into the travelling record, and the side effects of that instruction are suppressed from that point on.

The fault is taken only when the instruction reaches writeback. Instructions reach writeback in program order, so the oldest faulting instruction is always the one taken. In that cycle the block kills the instruction's register write and the writes of everything younger still in the pipe. It empties every pipeline register, asks fetch to resume at a fixed handler address, and latches the cause and two restart PCs. For an ordinary instruction these are its own PC and the next sequential PC. For an instruction in a delay slot they are the branch PC and the slot PC, so the handler can restart by re-running the branch.

The surrounding core supplies the fetch PC, a flag saying that the instruction in decode is a delayed branch, and one fault strobe with a cause per stage. It uses the kill, flush and redirect outputs to gate its own writes.

Top module: `exc_trk_top`

## Requirements
- R1: After reset no stage holds an instruction, commit_o, flush_o and all kill outputs are 0, and epc0_o, epc1_o, cause_o and epc_slot_o read 0.
- R2: A fault raised in fetch, decode, execute or memory is reported on commit_o in the cycle the instruction is in writeback. That is 4, 3, 2 or 1 cycles after the strobe, with the pipeline advancing one stage per clock.
- R3: When one instruction is hit by faults in several stages, the cause from the earliest stage is kept and later causes for it are ignored.
- R4: Faults are taken in program order. An older faulting instruction commits even when a younger one faulted first, and the younger instruction's fault is never taken.
- R5: In a commit cycle flush_o is 1 and redirect_pc_o equals HANDLER_PC. From the next cycle no stage holds an instruction, and the instruction fetched in the commit cycle is dropped.
- R6: wb_wr_kill_o is 1 exactly when the instruction in writeback carries a fault.
- R7: mem_store_kill_o is 1 when the instruction in memory carries a fault, raises one in that cycle, or is younger than an instruction committing a fault.
- R8: ex_kill_o is 1 when the instruction in execute carries a fault, raises one in that cycle, or is younger than an instruction committing a fault.
- R9: One cycle after the commit of an instruction not in a delay slot, epc0_o is its PC, epc1_o is its PC plus INSTR_BYTES, and epc_slot_o is 0.
- R10: An instruction fetched while the decode stage holds a delayed branch (id_branch_i=1) is a delay-slot instruction. One cycle after its commit, epc0_o is the branch PC, epc1_o is its own PC, and epc_slot_o is 1.
- R11: A fault strobe raised for a stage that holds no instruction has no effect.
- R12: One cycle after a commit, cause_o holds the cause code kept for the committed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid_i | input | 1 | An instruction is in fetch |
| if_pc_i | input | PC_W | PC of the instruction in fetch |
| id_branch_i | input | 1 | The decode instruction is a delayed branch |
| flt_if_i | input | 1 | Fault raised in fetch |
| cause_if_i | input | CAUSE_W | Fetch fault cause |
| flt_id_i | input | 1 | Fault raised in decode |
| cause_id_i | input | CAUSE_W | Decode fault cause |
| flt_ex_i | input | 1 | Fault raised in execute |
| cause_ex_i | input | CAUSE_W | Execute fault cause |
| flt_mem_i | input | 1 | Fault raised in memory |
| cause_mem_i | input | CAUSE_W | Memory fault cause |
| ex_kill_o | output | 1 | Suppress execute-stage side effects |
| mem_store_kill_o | output | 1 | Suppress the memory-stage store |
| wb_wr_kill_o | output | 1 | Suppress the writeback register write |
| commit_o | output | 1 | A fault is taken this cycle |
| flush_o | output | 1 | Empty the pipeline registers |
| redirect_pc_o | output | PC_W | Fetch address after a commit |
| epc0_o | output | PC_W | First restart PC |
| epc1_o | output | PC_W | Second restart PC |
| cause_o | output | CAUSE_W | Cause of the last taken fault |
| epc_slot_o | output | 1 | Last taken fault was in a delay slot |

## Verification
The hard case is a commit in writeback in the same cycle that the younger instruction in memory raises its own fault. The store kill must then come from two sources at once, and the younger fault must vanish in the flush instead of committing one cycle later. A directed sequence sets this up: an older instruction faults in execute and its successor strobes a memory fault exactly as the older one reaches writeback. The bench checks that the store kill, flush and redirect rise together, that the saved PCs name the older instruction, and that the commit count does not grow afterwards. Random traffic with sparse faults on every stage creates more such overlaps, and a cycle-level model in the bench judges each one.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;
    parameter int PC_W        = 32;
    parameter int CAUSE_W     = 5;
    parameter int INSTR_BYTES = 4;
    parameter int N_STAGE     = 4;               // stages that may raise a fault
    localparam int N_BND      = N_STAGE;         // pipeline registers IF/ID .. MEM/WB
    localparam int WB_IDX     = N_BND - 1;

    typedef struct packed {
        logic               vld;
        logic [PC_W-1:0]    pc;
        logic               slot;
        logic [PC_W-1:0]    bpc;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } stat_t;

    localparam stat_t STAT_NOP = '0;
endpackage

// File: rtl/exc_merge.sv
import exc_trk_pkg::*;

// Folds one stage's fault strobe into the status record of the instruction it holds.
module exc_merge (
    input  logic               clk,
    input  logic               rst_n,
    input  stat_t              stat_i,
    input  logic               flt_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output stat_t              stat_o,
    output logic               kill_o
);
    logic take_new;

    always_comb begin
        stat_o   = stat_i;
        take_new = stat_i.vld && flt_i && !stat_i.exc;
        if (take_new) begin
            stat_o.exc   = 1'b1;
            stat_o.cause = cause_i;
        end
        kill_o = stat_i.vld && (stat_i.exc || flt_i);
    end

    // earlier cause is never replaced
    assert_first_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_i.vld && stat_i.exc) |-> (stat_o.cause == stat_i.cause));

    // bubbles never pick up a fault
    assert_bubble_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_i.vld && !stat_i.exc) |-> !stat_o.exc);
endmodule

// File: rtl/exc_commit.sv
import exc_trk_pkg::*;

// Writeback decision and restart-PC capture.
module exc_commit (
    input  logic               clk,
    input  logic               rst_n,
    input  stat_t              wb_i,
    output logic               commit_o,
    output logic [PC_W-1:0]    epc0_o,
    output logic [PC_W-1:0]    epc1_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               slot_o
);
    typedef struct packed {
        logic [PC_W-1:0]    epc0;
        logic [PC_W-1:0]    epc1;
        logic [CAUSE_W-1:0] cause;
        logic               slot;
    } save_t;

    save_t save_d, save_q;
    logic  take;

    always_comb begin
        take   = wb_i.vld && wb_i.exc;
        save_d = save_q;
        if (take) begin
            save_d.cause = wb_i.cause;
            save_d.slot  = wb_i.slot;
            if (wb_i.slot) begin
                save_d.epc0 = wb_i.bpc;
                save_d.epc1 = wb_i.pc;
            end else begin
                save_d.epc0 = wb_i.pc;
                save_d.epc1 = wb_i.pc + PC_W'(INSTR_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) save_q <= '0;
        else        save_q <= save_d;
    end

    assign commit_o = take;
    assign epc0_o   = save_q.epc0;
    assign epc1_o   = save_q.epc1;
    assign cause_o  = save_q.cause;
    assign slot_o   = save_q.slot;

    assert_seq_epc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wb_i.slot) |=> (epc1_o == epc0_o + PC_W'(INSTR_BYTES)) && !slot_o);

    assert_slot_epc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wb_i.slot) |=> slot_o && (epc1_o == $past(wb_i.pc)));
endmodule

// File: rtl/exc_trk_top.sv
import exc_trk_pkg::*;

module exc_trk_top #(
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               if_valid_i,
    input  logic [PC_W-1:0]    if_pc_i,
    input  logic               id_branch_i,
    input  logic               flt_if_i,
    input  logic [CAUSE_W-1:0] cause_if_i,
    input  logic               flt_id_i,
    input  logic [CAUSE_W-1:0] cause_id_i,
    input  logic               flt_ex_i,
    input  logic [CAUSE_W-1:0] cause_ex_i,
    input  logic               flt_mem_i,
    input  logic [CAUSE_W-1:0] cause_mem_i,
    output logic               ex_kill_o,
    output logic               mem_store_kill_o,
    output logic               wb_wr_kill_o,
    output logic               commit_o,
    output logic               flush_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    output logic [PC_W-1:0]    epc0_o,
    output logic [PC_W-1:0]    epc1_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               epc_slot_o
);
    // pipe_q[0]=IF/ID, [1]=ID/EX, [2]=EX/MEM, [3]=MEM/WB
    stat_t pipe_d [N_BND];
    stat_t pipe_q [N_BND];

    stat_t              stage_in  [N_STAGE];
    stat_t              stage_out [N_STAGE];
    logic               stage_kill[N_STAGE];
    logic               flt_v     [N_STAGE];
    logic [CAUSE_W-1:0] cause_v   [N_STAGE];
    logic               commit;

    always_comb begin
        flt_v[0] = flt_if_i;  cause_v[0] = cause_if_i;
        flt_v[1] = flt_id_i;  cause_v[1] = cause_id_i;
        flt_v[2] = flt_ex_i;  cause_v[2] = cause_ex_i;
        flt_v[3] = flt_mem_i; cause_v[3] = cause_mem_i;
    end

    // fetch stage record is built from the inputs
    always_comb begin
        stage_in[0]       = STAT_NOP;
        stage_in[0].vld   = if_valid_i;
        stage_in[0].pc    = if_pc_i;
        stage_in[0].slot  = if_valid_i && id_branch_i && pipe_q[0].vld;
        stage_in[0].bpc   = pipe_q[0].pc;
    end

    genvar s;
    generate
        for (s = 1; s < N_STAGE; s++) begin : g_feed
            assign stage_in[s] = pipe_q[s-1];
        end
        for (s = 0; s < N_STAGE; s++) begin : g_merge
            exc_merge i_merge (
                .clk    (clk),
                .rst_n  (rst_n),
                .stat_i (stage_in[s]),
                .flt_i  (flt_v[s]),
                .cause_i(cause_v[s]),
                .stat_o (stage_out[s]),
                .kill_o (stage_kill[s])
            );
        end
    endgenerate

    exc_commit i_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_i    (pipe_q[WB_IDX]),
        .commit_o(commit),
        .epc0_o  (epc0_o),
        .epc1_o  (epc1_o),
        .cause_o (cause_o),
        .slot_o  (epc_slot_o)
    );

    always_comb begin
        for (int b = 0; b < N_BND; b++) begin
            pipe_d[b] = commit ? STAT_NOP : stage_out[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BND; b++) pipe_q[b] <= STAT_NOP;
        end else begin
            for (int b = 0; b < N_BND; b++) pipe_q[b] <= pipe_d[b];
        end
    end

    assign ex_kill_o        = stage_kill[2] || (commit && stage_in[2].vld);
    assign mem_store_kill_o = stage_kill[3] || (commit && stage_in[3].vld);
    assign wb_wr_kill_o     = pipe_q[WB_IDX].vld && pipe_q[WB_IDX].exc;
    assign commit_o         = commit;
    assign flush_o          = commit;
    assign redirect_pc_o    = HANDLER_PC;

    logic any_vld;
    always_comb begin
        any_vld = 1'b0;
        for (int b = 0; b < N_BND; b++) any_vld = any_vld | pipe_q[b].vld;
    end

    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !any_vld);

    assert_one_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_wb_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wb_wr_kill_o);

    assert_store_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q[2].vld && pipe_q[2].exc) |-> mem_store_kill_o);
endmodule

// File: tb/test_exc_trk_top.sv
module test_exc_trk_top;
    localparam int PW = 32;
    localparam int CW = 5;
    localparam logic [PW-1:0] HPC = 32'h0000_0080;

    typedef struct {
        bit          vld;
        bit [PW-1:0] pc;
        bit          slot;
        bit [PW-1:0] bpc;
        bit          exc;
        bit [CW-1:0] cause;
    } mrec_t;

    logic clk = 0;
    logic rst_n = 0;
    always #2 clk = ~clk;

    logic          if_valid_i = 0, id_branch_i = 0;
    logic [PW-1:0] if_pc_i = '0;
    logic          flt_if_i = 0, flt_id_i = 0, flt_ex_i = 0, flt_mem_i = 0;
    logic [CW-1:0] cause_if_i = '0, cause_id_i = '0, cause_ex_i = '0, cause_mem_i = '0;
    logic          ex_kill_o, mem_store_kill_o, wb_wr_kill_o, commit_o, flush_o, epc_slot_o;
    logic [PW-1:0] redirect_pc_o, epc0_o, epc1_o;
    logic [CW-1:0] cause_o;

    exc_trk_top #(.HANDLER_PC(HPC)) i_exc_trk_top (.*);

    int errors = 0, checks = 0, cyc = 0, commits = 0, commit_cyc = -1;
    mrec_t m[4];
    bit [PW-1:0] e_epc0, e_epc1; bit [CW-1:0] e_cause; bit e_slot;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic mrec_t merge(mrec_t r, bit f, bit [CW-1:0] c);
        mrec_t o = r;
        if (r.vld && f && !r.exc) begin o.exc = 1; o.cause = c; end
        return o;
    endfunction

    // one clock: check outputs depending on present inputs, advance model, check saved values
    task automatic cycle();
        mrec_t in0, nx[4];
        bit cm;
        #1;
        cm = m[3].vld && m[3].exc;
        chk("R2 commit", commit_o, cm);
        chk("R5 flush", flush_o, cm);
        chk("R5 redirect", redirect_pc_o, HPC);
        chk("R6 wbkill", wb_wr_kill_o, cm);
        chk("R7 storekill", mem_store_kill_o, m[2].vld && (m[2].exc || flt_mem_i || cm));
        chk("R8 exkill", ex_kill_o, m[1].vld && (m[1].exc || flt_ex_i || cm));
        if (cm) begin
            commits++; commit_cyc = cyc;
            e_cause = m[3].cause; e_slot = m[3].slot;
            if (m[3].slot) begin e_epc0 = m[3].bpc; e_epc1 = m[3].pc; end
            else begin e_epc0 = m[3].pc; e_epc1 = m[3].pc + 4; end
        end
        in0.vld = if_valid_i; in0.pc = if_pc_i; in0.exc = 0; in0.cause = 0;
        in0.slot = if_valid_i && id_branch_i && m[0].vld; in0.bpc = m[0].pc;
        nx[0] = merge(in0, flt_if_i, cause_if_i);
        nx[1] = merge(m[0], flt_id_i, cause_id_i);
        nx[2] = merge(m[1], flt_ex_i, cause_ex_i);
        nx[3] = merge(m[2], flt_mem_i, cause_mem_i);
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (cm) begin nx[i].vld = 0; nx[i].exc = 0; nx[i].cause = 0; nx[i].pc = 0;
                          nx[i].bpc = 0; nx[i].slot = 0; end
            m[i] = nx[i];
        end
        cyc++;
        @(negedge clk);
        chk("R9 R10 epc0", epc0_o, e_epc0);
        chk("R9 R10 epc1", epc1_o, e_epc1);
        chk("R12 cause", cause_o, e_cause);
        chk("R10 slot", epc_slot_o, e_slot);
    endtask

    task automatic drv(bit iv, bit [PW-1:0] pc, bit br,
                       bit fi, bit [CW-1:0] ci, bit fd, bit [CW-1:0] cd,
                       bit fe, bit [CW-1:0] ce, bit fm, bit [CW-1:0] cmm);
        if_valid_i = iv; if_pc_i = pc; id_branch_i = br;
        flt_if_i = fi; cause_if_i = ci; flt_id_i = fd; cause_id_i = cd;
        flt_ex_i = fe; cause_ex_i = ce; flt_mem_i = fm; cause_mem_i = cmm;
        cycle();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int start, base;
        for (int i = 0; i < 4; i++) m[i] = '{0, 0, 0, 0, 0, 0};
        e_epc0 = 0; e_epc1 = 0; e_cause = 0; e_slot = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 commit", commit_o, 0); chk("R1 flush", flush_o, 0);
        chk("R1 wbkill", wb_wr_kill_o, 0); chk("R1 storekill", mem_store_kill_o, 0);
        chk("R1 exkill", ex_kill_o, 0); chk("R1 epc0", epc0_o, 0);
        chk("R1 epc1", epc1_o, 0); chk("R1 cause", cause_o, 0); chk("R1 slot", epc_slot_o, 0);
        rst_n = 1;

        // R2/R9/R12: fetch fault commits four cycles later
        start = cyc;
        drv(1, 32'h100, 0, 1, 5'd3, 0, 0, 0, 0, 0, 0);
        idle(5);
        chk("R2 latency", commit_cyc, start + 4);
        chk("R9 epc0", epc0_o, 32'h100); chk("R9 epc1", epc1_o, 32'h104);
        chk("R12 cause", cause_o, 3); chk("R9 slot", epc_slot_o, 0);

        // R3: decode then execute fault on one instruction keeps the decode cause
        drv(1, 32'h200, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 1, 5'd7, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 1, 5'd9, 0, 0);
        idle(4);
        chk("R3 cause", cause_o, 7); chk("R3 epc0", epc0_o, 32'h200);

        // R4: younger faults first, older commits, younger never does
        base = commits;
        drv(1, 32'h300, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drv(1, 32'h304, 0, 1, 5'd2, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'd6);
        idle(6);
        chk("R4 count", commits - base, 1);
        chk("R4 epc0", epc0_o, 32'h300); chk("R4 cause", cause_o, 6);

        // R10: delay-slot instruction faults
        drv(1, 32'h400, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drv(1, 32'h404, 1, 1, 5'd1, 0, 0, 0, 0, 0, 0);
        idle(5);
        chk("R10 epc0", epc0_o, 32'h400); chk("R10 epc1", epc1_o, 32'h404);
        chk("R10 slot", epc_slot_o, 1);

        // R11: strobes on an empty pipe do nothing
        base = commits;
        drv(0, 0, 0, 1, 5'd11, 1, 5'd12, 1, 5'd13, 1, 5'd14);
        idle(5);
        chk("R11 count", commits - base, 0); chk("R11 cause", cause_o, 1);

        // R5/R7: commit coincides with a memory fault of the younger instruction
        base = commits;
        drv(1, 32'h500, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drv(1, 32'h504, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drv(1, 32'h508, 0, 0, 0, 0, 0, 1, 5'd4, 0, 0);
        drv(1, 32'h50c, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        if_valid_i = 1; if_pc_i = 32'h510; flt_mem_i = 1; cause_mem_i = 5'd8;
        #1;
        chk("R5 flush", flush_o, 1); chk("R7 storekill", mem_store_kill_o, 1);
        chk("R8 exkill", ex_kill_o, 1);
        flt_mem_i = 0;
        flt_mem_i = 1;
        cycle();
        idle(6);
        chk("R5 count", commits - base, 1); chk("R5 cause", cause_o, 4);

        // random traffic with sparse faults
        for (int n = 0; n < 3000; n++) begin
            drv($urandom_range(0, 3) != 0, $urandom & 32'hffff_fffc, $urandom_range(0, 4) == 0,
                $urandom_range(0, 29) == 0, CW'($urandom), $urandom_range(0, 29) == 0, CW'($urandom),
                $urandom_range(0, 29) == 0, CW'($urandom), $urandom_range(0, 29) == 0, CW'($urandom));
        end
        idle(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule